// File: doc/BRIEF.md
# Register-Bus 3x3 Signed Matrix Multiplier

This peripheral takes two 3x3 matrices of signed 16-bit integers from a host over a simple single-cycle register bus and computes their product. The host writes the eighteen operand elements into one address window, and the final write starts the computation. It then polls a status word and reads the nine product elements back from the start of the same window. For any offset, a read returns product data or status. It never returns the stored operand.

Inside are two operand memories, a sequencer that performs one signed multiply-accumulate per clock, a double-buffered result store and the address decode. Every element uses its own 32-bit bus word, in row-major order. Each product element is the sum of three 32-bit partial products, formed without overflow in a 34-bit accumulator. The sum is saturated to the signed 16-bit range when it is stored. While a computation is running, the host keeps reading the previous complete product, and operand writes are held off.

Top module: `matmul_periph`

## Requirements
- R1: After reset, the status word reads 0, and reads of word offsets 0 to 8 return 0.
- R2: The window matches when address bits 31:10 equal those of base 0x40500000, and the word offset is address bits 9:2. A write at offset r*3+c stores A[r][c] for offsets 0 to 8, and a write at offset 9+r*3+c stores B[r][c], both from write-data bits 15:0 with bits 31:16 ignored. After a computation, a read at offset r*3+c returns the sum over k of A[r][k]*B[k][c].
- R3: A result above 32767 is stored as 32767, and a result below -32768 is stored as -32768.
- R4: An accepted write to offset 17 while idle starts the computation. Status bit 0 (busy) reads 1 from the next cycle. Within 32 cycles of the start, busy reads 0 and status bit 1 (done) reads 1. Busy and done are never both 1.
- R5: Any accepted write to offsets 0 to 17 clears done.
- R6: While busy, reads of offsets 0 to 8 return the product of the previous completed computation.
- R7: While busy, writes to offsets 0 to 17 are ignored. They change no operand, start nothing and leave done unchanged.
- R8: Reads of offsets 9 to 255 other than the status offset 0x80 return 0, and so do reads outside the window. Writes to those places, and writes to the status offset, change nothing.
- R9: Read data is registered. It is valid in the cycle after the read-enable cycle, with the 16-bit result sign-extended to 32 bits and status in bits 1:0 with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, element in bits 15:0 |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_re | input | 1 | Read enable, one cycle per read |
| bus_rdata | output | 32 | Registered read data |

## Verification
Read data changes at the clock edge that samples read-enable. The bench therefore raises read-enable just after one falling edge and samples the data at the next falling edge. Busy must read 1 on the first status read after the starting write. The product is written at the 29th edge after the start, so done must appear within 32 cycles, and the bench polls status for a bounded number of reads. The reads made while busy, and the writes that must be ignored, are issued in the roughly 20 cycles after the start, well before the product commits.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // Where an in-window word offset lands.
  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_LOWER  = 2'd1,
    REG_UPPER  = 2'd2,
    REG_STATUS = 2'd3
  } mm_region_e;

  // Positions inside the status word.
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_DONE_BIT = 1;
endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode
  import mm_pkg::*;
#(
  parameter int unsigned     BUS_W      = 32,
  parameter logic [31:0]     BASE       = 32'h4050_0000,
  parameter int unsigned     WIN_BITS   = 10,
  parameter int unsigned     NELEM      = 9,
  parameter int unsigned     STATUS_OFF = 128,
  parameter int unsigned     IW         = 4
) (
  input  logic [BUS_W-1:0] addr,
  output mm_region_e       region,
  output logic [IW-1:0]    elem_idx
);
  localparam int unsigned OW = WIN_BITS - 2;

  logic          in_win;
  logic [OW-1:0] off;

  assign in_win = (addr[BUS_W-1:WIN_BITS] == BASE[BUS_W-1:WIN_BITS]);
  assign off    = addr[WIN_BITS-1:2];

  always_comb begin
    region   = REG_NONE;
    elem_idx = '0;
    if (in_win) begin
      if (off < OW'(NELEM)) begin
        region   = REG_LOWER;
        elem_idx = IW'(off);
      end else if (off < OW'(2 * NELEM)) begin
        region   = REG_UPPER;
        elem_idx = IW'(off - OW'(NELEM));
      end else if (off == OW'(STATUS_OFF)) begin
        region   = REG_STATUS;
      end
    end
  end
endmodule

// File: rtl/mm_operand_bank.sv
module mm_operand_bank #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NELEM = 9,
  parameter int unsigned IW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  // One write port and one synchronous read port, so the array can map to RAM.
  logic [DW-1:0] mem [NELEM];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/mm_mac_engine.sv
module mm_mac_engine #(
  parameter int unsigned DIM  = 3,
  parameter int unsigned DW   = 16,
  parameter int unsigned ACCW = 34,
  parameter int unsigned IW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          done_clr,
  output logic [IW-1:0] a_idx,
  output logic [IW-1:0] b_idx,
  input  logic [DW-1:0] a_data,
  input  logic [DW-1:0] b_data,
  output logic          res_we,
  output logic [IW-1:0] res_idx,
  output logic [DW-1:0] res_data,
  output logic          commit,
  output logic          busy,
  output logic          done
);
  localparam int unsigned CW    = (DIM > 1) ? $clog2(DIM) : 1;
  localparam int unsigned NELEM = DIM * DIM;
  localparam logic signed [ACCW-1:0] SMAX = ACCW'((1 << (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] SMIN = -SMAX - ACCW'(1);

  logic [CW-1:0] ci, cj, ck;
  logic          issuing;
  logic          last_i, last_j, last_k;

  assign last_i = (ci == CW'(DIM - 1));
  assign last_j = (cj == CW'(DIM - 1));
  assign last_k = (ck == CW'(DIM - 1));

  assign a_idx = IW'(ci * DIM + ck);
  assign b_idx = IW'(ck * DIM + cj);

  // Stage 1 tag: travels with the registered operand reads.
  logic          v1, first1, last1;
  logic [IW-1:0] ridx1;
  // Stage 2: registered product.
  logic                   v2, first2, last2;
  logic [IW-1:0]          ridx2;
  logic signed [2*DW-1:0] prod;
  // Stage 3: accumulator.
  logic signed [ACCW-1:0] acc, sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      done    <= 1'b0;
      ci      <= '0;
      cj      <= '0;
      ck      <= '0;
    end else begin
      if (start && !busy) begin
        busy    <= 1'b1;
        issuing <= 1'b1;
        done    <= 1'b0;
        ci      <= '0;
        cj      <= '0;
        ck      <= '0;
      end else begin
        if (done_clr) done <= 1'b0;
        if (issuing) begin
          if (!last_k) begin
            ck <= ck + CW'(1);
          end else begin
            ck <= '0;
            if (!last_j) begin
              cj <= cj + CW'(1);
            end else begin
              cj <= '0;
              if (!last_i) ci <= ci + CW'(1);
              else         issuing <= 1'b0;
            end
          end
        end
        if (commit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= issuing;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    first1 <= (ck == '0);
    last1  <= last_k;
    ridx1  <= IW'(ci * DIM + cj);
    first2 <= first1;
    last2  <= last1;
    ridx2  <= ridx1;
    prod   <= $signed(a_data) * $signed(b_data);
    if (v2) acc <= sum;
  end

  always_comb begin
    sum = (first2 ? '0 : acc) + ACCW'(prod);
    if (sum > SMAX)      res_data = DW'(SMAX);
    else if (sum < SMIN) res_data = DW'(SMIN);
    else                 res_data = sum[DW-1:0];
  end

  assign res_we  = v2 && last2;
  assign res_idx = ridx2;
  assign commit  = res_we && (ridx2 == IW'(NELEM - 1));
endmodule

// File: rtl/mm_result_bank.sv
module mm_result_bank #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NELEM = 9,
  parameter int unsigned IW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  // Two banks: the engine fills the hidden one, and commit swaps them.
  logic [DW-1:0] bank [2][NELEM];
  logic          shown;

  always_ff @(posedge clk) begin
    if (rst) begin
      shown <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < int'(NELEM); e++)
          bank[b][e] <= '0;
    end else begin
      if (wr_en)  bank[~shown][wr_idx] <= wr_data;
      if (commit) shown <= ~shown;
    end
  end

  assign rd_data = (rd_idx < IW'(NELEM)) ? bank[shown][rd_idx] : '0;
endmodule

// File: rtl/matmul_periph.sv
module matmul_periph
  import mm_pkg::*;
#(
  parameter int unsigned BUS_W      = 32,
  parameter logic [31:0] BASE       = 32'h4050_0000,
  parameter int unsigned WIN_BITS   = 10,
  parameter int unsigned DIM        = 3,
  parameter int unsigned DW         = 16,
  parameter int unsigned STATUS_OFF = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [BUS_W-1:0] bus_rdata
);
  localparam int unsigned NELEM = DIM * DIM;
  localparam int unsigned IW    = $clog2(NELEM);
  localparam int unsigned ACCW  = 2 * DW + $clog2(DIM);

  mm_region_e    region;
  logic [IW-1:0] elem_idx;
  logic          busy, done, commit;
  logic          wr_ok, wr_a, wr_b, start;
  logic [IW-1:0] a_idx, b_idx, res_idx;
  logic [DW-1:0] a_data, b_data, res_data, res_rd;
  logic          res_we;

  mm_addr_decode #(
    .BUS_W(BUS_W), .BASE(BASE), .WIN_BITS(WIN_BITS),
    .NELEM(NELEM), .STATUS_OFF(STATUS_OFF), .IW(IW)
  ) u_dec (
    .addr(bus_addr), .region(region), .elem_idx(elem_idx)
  );

  assign wr_ok = bus_we && !busy;
  assign wr_a  = wr_ok && (region == REG_LOWER);
  assign wr_b  = wr_ok && (region == REG_UPPER);
  assign start = wr_b && (elem_idx == IW'(NELEM - 1));

  mm_operand_bank #(.DW(DW), .NELEM(NELEM), .IW(IW)) u_opa (
    .clk(clk), .wr_en(wr_a), .wr_idx(elem_idx), .wr_data(bus_wdata[DW-1:0]),
    .rd_idx(a_idx), .rd_data(a_data)
  );

  mm_operand_bank #(.DW(DW), .NELEM(NELEM), .IW(IW)) u_opb (
    .clk(clk), .wr_en(wr_b), .wr_idx(elem_idx), .wr_data(bus_wdata[DW-1:0]),
    .rd_idx(b_idx), .rd_data(b_data)
  );

  mm_mac_engine #(.DIM(DIM), .DW(DW), .ACCW(ACCW), .IW(IW)) u_eng (
    .clk(clk), .rst(rst), .start(start), .done_clr(wr_a || wr_b),
    .a_idx(a_idx), .b_idx(b_idx), .a_data(a_data), .b_data(b_data),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
    .commit(commit), .busy(busy), .done(done)
  );

  mm_result_bank #(.DW(DW), .NELEM(NELEM), .IW(IW)) u_res (
    .clk(clk), .rst(rst), .wr_en(res_we), .wr_idx(res_idx), .wr_data(res_data),
    .commit(commit), .rd_idx(elem_idx), .rd_data(res_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= '0;
      case (region)
        REG_LOWER:  bus_rdata <= {{(BUS_W-DW){res_rd[DW-1]}}, res_rd};
        REG_STATUS: begin
          bus_rdata[STAT_BUSY_BIT] <= busy;
          bus_rdata[STAT_DONE_BIT] <= done;
        end
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int unsigned BUS_W    = 32,
  parameter logic [31:0] BASE     = 32'h4050_0000,
  parameter int unsigned WIN_BITS = 10,
  parameter int unsigned DIM      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [BUS_W-1:0] bus_addr,
  input logic             bus_we,
  input logic             bus_re,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             busy,
  input logic             done
);
  localparam int unsigned OW    = WIN_BITS - 2;
  localparam int unsigned NELEM = DIM * DIM;
  localparam int unsigned LIMIT = DIM * DIM * DIM + 4;

  logic          in_win;
  logic [OW-1:0] off;
  logic [15:0]   busy_len;

  assign in_win = (bus_addr[BUS_W-1:WIN_BITS] == BASE[BUS_W-1:WIN_BITS]);
  assign off    = bus_addr[WIN_BITS-1:2];

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 16'd1;
    else           busy_len <= '0;
  end

  // R4: an accepted write of the last B element starts the engine
  a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
    (bus_we && in_win && off == OW'(2 * NELEM - 1) && !busy) |=> busy);

  // R4: the run finishes within its bounded window
  a_r4_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_len <= 16'(LIMIT));

  // R4: busy and done never together
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R5: an accepted operand write clears done
  a_r5_done_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_we && in_win && off < OW'(2 * NELEM) && !busy) |=> !done);

  // R7: writes while busy neither abort nor restart the run
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we) |=> (busy || done));

  // R8: reads outside the window return zero
  a_r8_outside_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !in_win) |=> (bus_rdata == '0));
endmodule

bind matmul_periph mm_checker #(
  .BUS_W(BUS_W), .BASE(BASE), .WIN_BITS(WIN_BITS), .DIM(DIM)
) u_mm_checker (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .busy(busy), .done(done)
);

// File: tb/test_matmul_periph.sv
`timescale 1ns/1ps
module test_matmul_periph;
  localparam logic [31:0] BASE = 32'h4050_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  int ma [9];
  int mb [9];
  int prev [9];
  int cur [9];

  always #10 clk = ~clk;

  matmul_periph i_matmul_periph (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  function automatic int sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int expect_elem(int r, int c);
    longint s = 0;
    for (int k = 0; k < 3; k++)
      s += longint'(ma[r*3+k]) * longint'(mb[k*3+c]);
    return sat16(s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [31:0] addr, logic [31:0] data);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [31:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = addr; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    data = bus_rdata;
  endtask

  function automatic logic [31:0] waddr(int off);
    return BASE + 32'(off * 4);
  endfunction

  task automatic load_operands(bit junk_upper);
    for (int e = 0; e < 9; e++)
      bus_write(waddr(e), {junk_upper ? 16'($urandom) : 16'h0, 16'(ma[e])});
    for (int e = 0; e < 9; e++)
      bus_write(waddr(9 + e), {junk_upper ? 16'($urandom) : 16'h0, 16'(mb[e])});
  endtask

  task automatic wait_done(string req);
    logic [31:0] st;
    int n = 0;
    st = '0;
    while (n < 16 && st[1] !== 1'b1) begin
      bus_read(waddr(128), st);
      n++;
    end
    check(req, st, 32'h2);
  endtask

  task automatic check_results(string req);
    logic [31:0] d;
    for (int e = 0; e < 9; e++) begin
      cur[e] = expect_elem(e / 3, e % 3);
      bus_read(waddr(e), d);
      check(req, d, 32'(cur[e]));
    end
  endtask

  task automatic fill_all(int av, int bv);
    for (int e = 0; e < 9; e++) begin
      ma[e] = av;
      mb[e] = bv;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bus_read(waddr(128), d);
    check("R1 status", d, 32'h0);
    for (int e = 0; e < 9; e++) begin
      bus_read(waddr(e), d);
      check("R1 result", d, 32'h0);
    end

    // R2 R4: worked example, with junk in the upper halves of the writes
    for (int e = 0; e < 9; e++) begin
      ma[e] = e + 1;
      mb[e] = e + 10;
    end
    load_operands(1'b1);
    bus_read(waddr(128), d);
    check("R4 busy after start", d, 32'h1);
    wait_done("R4 done");
    check_results("R2 example");
    check("R2 spot 84", 32'(cur[0]), 32'd84);
    check("R2 spot 366", 32'(cur[8]), 32'd366);

    // R3: saturation in both directions
    fill_all(32767, 32767);
    load_operands(1'b0);
    wait_done("R4 done");
    check_results("R3 positive saturation");
    fill_all(-32768, 32767);
    load_operands(1'b0);
    wait_done("R4 done");
    check_results("R3 negative saturation");
    fill_all(-32768, -32768);
    load_operands(1'b0);
    wait_done("R4 done");
    check_results("R3 product of negatives");

    // R2 R9: random operands, small and full range, with sign extension
    for (int t = 0; t < 24; t++) begin
      for (int e = 0; e < 9; e++) begin
        if (t % 2 == 0) begin
          ma[e] = int'($urandom_range(200)) - 100;
          mb[e] = int'($urandom_range(200)) - 100;
        end else begin
          ma[e] = int'(16'sh0 + $signed(16'($urandom)));
          mb[e] = int'(16'sh0 + $signed(16'($urandom)));
        end
      end
      load_operands(t % 3 == 0);
      wait_done("R4 done");
      check_results("R2 R9 random");
    end

    // R6 R7: reads and writes while busy
    for (int e = 0; e < 9; e++) prev[e] = cur[e];
    for (int e = 0; e < 9; e++) begin
      ma[e] = 3 - e;
      mb[e] = 2 * e - 7;
    end
    load_operands(1'b0);
    bus_read(waddr(128), d);
    check("R4 busy", d, 32'h1);
    bus_write(waddr(0), 32'h0000_1234);
    bus_write(waddr(17), 32'h0000_4321);
    for (int e = 0; e < 9; e++) begin
      bus_read(waddr(e), d);
      check("R6 previous while busy", d, 32'(prev[e]));
    end
    wait_done("R7 done after ignored writes");
    check_results("R7 operands kept");

    // R5: an operand write clears done
    bus_write(waddr(4), 32'h0000_0005);
    bus_read(waddr(128), d);
    check("R5 done cleared", d, 32'h0);
    ma[4] = 5;
    bus_write(waddr(17), 32'(mb[8] & 16'hffff));
    wait_done("R4 done");
    check_results("R5 rerun");

    // R8: unmapped writes and reads
    bus_write(waddr(20), 32'h0000_7fff);
    bus_write(waddr(128), 32'hffff_ffff);
    bus_write(32'h4050_0400, 32'h0000_1111);
    bus_write(32'h0000_0000, 32'h0000_2222);
    bus_read(waddr(128), d);
    check("R8 status unchanged", d, 32'h2);
    bus_read(waddr(9), d);
    check("R8 B offset reads zero", d, 32'h0);
    bus_read(waddr(17), d);
    check("R8 last B offset reads zero", d, 32'h0);
    bus_read(waddr(20), d);
    check("R8 unmapped reads zero", d, 32'h0);
    bus_read(waddr(127), d);
    check("R8 below status reads zero", d, 32'h0);
    bus_read(32'h4050_0400, d);
    check("R8 outside window reads zero", d, 32'h0);
    check_results("R8 results unchanged");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule